// File: doc/BRIEF.md
# SD-first card mode sequencer

This block runs on the host side of a removable memory card slot whose sockets share the SD data lines with a PCIe link. When a card is seen, it waits for the card-detect input to stay stable and for the 3.3 V rail to be good. It then starts the SD bus clock and asks the SD command engine to run initialization only up to the interface-condition command, CMD8. The PCIe-support flag in the CMD8 response decides what happens next.

A card without PCIe support stays on the SD bus with the clock running. For a PCIe-capable card the sequencer stops the SD clock, then turns on the 1.8 V rail, and then raises a presence signal toward the PCIe host controller. That presence signal is generated here and does not come from a socket pin. Once in PCIe mode the block holds that state until the card is pulled out. A removal, or loss of the 3.3 V rail, drops every output in a single clock. There is no path from PCIe mode back to SD mode.

Top module: `sd_first_seq`

## Requirements
- R1: While rst_ni is low and after it is released, sd_clk_en_o, cmd8_req_o, vdd2_en_o and pcie_prsnt_en_o are 0 and mode_o is NONE (mode codes: NONE=2'b00, SD=2'b01, PCIE=2'b10, INIT=2'b11).
- R2: Insertion is acted on only after card_det_i and vdd1_good_i have both stayed high while dbnc_ticks_i tick_i pulses are counted. The count begins in the cycle after both are first seen high. In the clock after the count reaches dbnc_ticks_i, sd_clk_en_o and cmd8_req_o rise and mode_o becomes INIT. A limit of 0 starts the SD clock two clocks after insertion.
- R3: cmd8_req_o stays high, together with sd_clk_en_o, until a clock edge at which cmd8_done_i is high.
- R4: The PCIe-support flag is bit PCIE_BIT (default 8) of cmd8_resp_i, and it is sampled only on the edge where cmd8_done_i is high. No other bit of cmd8_resp_i affects the outcome.
- R5: When CMD8 completes with the flag at 0, cmd8_req_o falls, sd_clk_en_o stays high and mode_o becomes SD. The block then stays in SD mode, and further cmd8_done_i pulses have no effect.
- R6: When CMD8 completes with the flag at 1, the next clock has sd_clk_en_o at 0 with vdd2_en_o still 0. The clock after that raises vdd2_en_o. One clock later pcie_prsnt_en_o rises and mode_o becomes PCIE. mode_o reads INIT until then.
- R7: vdd2_en_o is 0 when a card is first inserted, and it is high only if vdd1_good_i was high at the previous edge. Loss of vdd1_good_i in any state clears all outputs on the next clock. While vdd1_good_i is low, an inserted card is not acted on.
- R8: PCIe mode is held as long as the card stays present and vdd1_good_i stays high, whatever cmd8_done_i and cmd8_resp_i do. The block never moves from PCIE back to SD.
- R9: card_det_i low at any clock edge clears all four enables and sets mode_o to NONE after that edge. This takes priority over a cmd8_done_i arriving on the same edge.
- R10: A drop of card_det_i during the debounce count discards the ticks counted so far. The full count starts again on the next insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_det_i | input | 1 | Socket card-detect, 1 = card present |
| vdd1_good_i | input | 1 | 3.3 V card rail is up |
| tick_i | input | 1 | Debounce time-base pulse |
| dbnc_ticks_i | input | CNT_W | Debounce length in ticks |
| cmd8_done_i | input | 1 | Command engine finished CMD8 (one-cycle strobe) |
| cmd8_resp_i | input | RESP_W | CMD8 response bits |
| sd_clk_en_o | output | 1 | Run the SD bus clock |
| cmd8_req_o | output | 1 | Ask the command engine to run initialization up to CMD8 |
| vdd2_en_o | output | 1 | Turn on the 1.8 V rail and steer the line switch to PCIe |
| pcie_prsnt_en_o | output | 1 | Presence signal to the PCIe host controller |
| mode_o | output | 2 | Card mode: NONE, SD, PCIE or INIT |

## Verification
Card removal can arrive on the same edge as the CMD8 completion strobe. Completion carries the PCIe flag and would start the power-up steps, while removal must win and leave every output low. The bench holds the sequencer in the CMD8 wait state, then drives card_det_i low and a completion with the PCIe flag set in the same cycle. It judges the result by requiring all enables at 0 and mode NONE after that edge, and still idle one clock later. The same kind of collision, between a 3.3 V rail drop and an established PCIe mode, is provoked and judged in the same way.

// File: rtl/sd_first_seq_pkg.sv
package sd_first_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DBNC   = 3'd1,
    ST_SDINIT = 3'd2,
    ST_SD     = 3'd3,
    ST_CLKOFF = 3'd4,
    ST_PWR    = 3'd5,
    ST_PCIE   = 3'd6
  } seq_st_e;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_SD   = 2'b01,
    MODE_PCIE = 2'b10,
    MODE_INIT = 2'b11
  } card_mode_e;

endpackage

// File: rtl/sd_first_seq_dbnc.sv
module sd_first_seq_dbnc #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!arm_i)                     cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = arm_i && (cnt_q >= limit_i);
endmodule

// File: rtl/sd_first_seq_fsm.sv
module sd_first_seq_fsm
  import sd_first_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    card_det_i,
  input  logic    vdd1_good_i,
  input  logic    dbnc_done_i,
  input  logic    cmd8_done_i,
  input  logic    pcie_sup_i,
  output seq_st_e st_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!card_det_i || !vdd1_good_i) begin
      st_d = ST_IDLE;  // removal or rail loss wins over everything
    end else begin
      unique case (st_q)
        ST_IDLE:   st_d = ST_DBNC;
        ST_DBNC:   if (dbnc_done_i) st_d = ST_SDINIT;
        ST_SDINIT: if (cmd8_done_i) st_d = pcie_sup_i ? ST_CLKOFF : ST_SD;
        ST_CLKOFF: st_d = ST_PWR;
        ST_PWR:    st_d = ST_PCIE;
        ST_SD:     st_d = ST_SD;
        ST_PCIE:   st_d = ST_PCIE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/sd_first_seq_out.sv
module sd_first_seq_out
  import sd_first_seq_pkg::*;
(
  input  seq_st_e    st_i,
  output logic       sd_clk_en_o,
  output logic       cmd8_req_o,
  output logic       vdd2_en_o,
  output logic       pcie_prsnt_en_o,
  output card_mode_e mode_o
);
  always_comb begin
    sd_clk_en_o     = 1'b0;
    cmd8_req_o      = 1'b0;
    vdd2_en_o       = 1'b0;
    pcie_prsnt_en_o = 1'b0;
    mode_o          = MODE_NONE;
    unique case (st_i)
      ST_SDINIT: begin sd_clk_en_o = 1'b1; cmd8_req_o = 1'b1; mode_o = MODE_INIT; end
      ST_SD:     begin sd_clk_en_o = 1'b1; mode_o = MODE_SD; end
      ST_CLKOFF: mode_o = MODE_INIT;
      ST_PWR:    begin vdd2_en_o = 1'b1; mode_o = MODE_INIT; end
      ST_PCIE:   begin vdd2_en_o = 1'b1; pcie_prsnt_en_o = 1'b1; mode_o = MODE_PCIE; end
      default:   mode_o = MODE_NONE;
    endcase
  end
endmodule

// File: rtl/sd_first_seq.sv
module sd_first_seq
  import sd_first_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RESP_W   = 12,
  parameter int PCIE_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_det_i,
  input  logic              vdd1_good_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  dbnc_ticks_i,
  input  logic              cmd8_done_i,
  input  logic [RESP_W-1:0] cmd8_resp_i,
  output logic              sd_clk_en_o,
  output logic              cmd8_req_o,
  output logic              vdd2_en_o,
  output logic              pcie_prsnt_en_o,
  output logic [1:0]        mode_o
);
  seq_st_e    st;
  logic       dbnc_done;
  card_mode_e mode;

  sd_first_seq_dbnc #(.CNT_W(CNT_W)) u_dbnc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (st == ST_DBNC),
    .tick_i  (tick_i),
    .limit_i (dbnc_ticks_i),
    .done_o  (dbnc_done)
  );

  sd_first_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .card_det_i  (card_det_i),
    .vdd1_good_i (vdd1_good_i),
    .dbnc_done_i (dbnc_done),
    .cmd8_done_i (cmd8_done_i),
    .pcie_sup_i  (cmd8_resp_i[PCIE_BIT]),
    .st_o        (st)
  );

  sd_first_seq_out u_out (
    .st_i            (st),
    .sd_clk_en_o     (sd_clk_en_o),
    .cmd8_req_o      (cmd8_req_o),
    .vdd2_en_o       (vdd2_en_o),
    .pcie_prsnt_en_o (pcie_prsnt_en_o),
    .mode_o          (mode)
  );

  assign mode_o = mode;
endmodule

// File: rtl/sd_first_seq_chk.sv
module sd_first_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       card_det_i,
  input logic       vdd1_good_i,
  input logic       cmd8_done_i,
  input logic       sd_clk_en_o,
  input logic       cmd8_req_o,
  input logic       vdd2_en_o,
  input logic       pcie_prsnt_en_o,
  input logic [1:0] mode_o
);
  AST_REQ_WITH_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd8_req_o |-> sd_clk_en_o);  // R3

  AST_CLK_OFF_BEFORE_VDD2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vdd2_en_o) |-> (!sd_clk_en_o && $past(!sd_clk_en_o)));  // R6

  AST_PRSNT_AFTER_VDD2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcie_prsnt_en_o |-> (vdd2_en_o && $past(vdd2_en_o) && mode_o == 2'b10));  // R6

  AST_VDD2_NEEDS_VDD1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdd2_en_o |-> $past(vdd1_good_i));  // R7

  AST_NO_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && card_det_i && vdd1_good_i) |=> mode_o == 2'b10);  // R8

  AST_REMOVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !card_det_i |=> (!sd_clk_en_o && !cmd8_req_o && !vdd2_en_o && !pcie_prsnt_en_o
                     && mode_o == 2'b00));  // R9

  AST_SD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && card_det_i && vdd1_good_i) |=> (mode_o == 2'b01 && sd_clk_en_o));  // R5
endmodule

bind sd_first_seq sd_first_seq_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .card_det_i      (card_det_i),
  .vdd1_good_i     (vdd1_good_i),
  .cmd8_done_i     (cmd8_done_i),
  .sd_clk_en_o     (sd_clk_en_o),
  .cmd8_req_o      (cmd8_req_o),
  .vdd2_en_o       (vdd2_en_o),
  .pcie_prsnt_en_o (pcie_prsnt_en_o),
  .mode_o          (mode_o)
);

// File: tb/sd_first_seq_tb.sv
module sd_first_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card = 1'b0, vdd1 = 1'b0, tick = 1'b0, done = 1'b0;
  logic [7:0]  dbnc = 8'd2;
  logic [11:0] resp = 12'h0AA;
  logic        clk_en, req, vdd2, prsnt;
  logic [1:0]  mode;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  sd_first_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .card_det_i(card), .vdd1_good_i(vdd1),
    .tick_i(tick), .dbnc_ticks_i(dbnc), .cmd8_done_i(done), .cmd8_resp_i(resp),
    .sd_clk_en_o(clk_en), .cmd8_req_o(req), .vdd2_en_o(vdd2),
    .pcie_prsnt_en_o(prsnt), .mode_o(mode)
  );

  // {card, vdd1, tick, done, pcie_flag} | {clk_en, req, vdd2, prsnt, mode}
  localparam logic [10:0] VEC [17] = '{
    11'b11000_000000, 11'b11100_000000, 11'b11100_000000, 11'b11000_110011,
    11'b11011_000011, 11'b11000_001011, 11'b11000_001110, 11'b11010_001110,
    11'b01000_000000, 11'b11100_000000, 11'b11100_000000, 11'b11100_000000,
    11'b11100_110011, 11'b11000_110011, 11'b11010_100001, 11'b11011_100001,
    11'b01000_000000
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1, 2, 3, 9, 10, 11, 12: return "R2";
      4, 5, 6:                   return "R6";
      7:                         return "R8";
      8, 16:                     return "R9";
      13:                        return "R3";
      14:                        return "R5";
      default:                   return "R4";
    endcase
  endfunction

  task automatic check(string r, logic [5:0] exp);
    logic [5:0] act;
    act = {clk_en, req, vdd2, prsnt, mode};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic drive(logic c, logic v, logic t, logic d, logic p);
    card = c; vdd1 = v; tick = t; done = d;
    resp = 12'h0AA | (12'(p) << 8);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 6'b000000);
    rst_n = 1'b1;
    step();
    check("R1", 6'b000000);

    for (int i = 0; i < 17; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      step();
      check(vec_req(i), VEC[i][5:0]);
    end

    // R9: removal on the same edge as a PCIe-flagged CMD8 completion
    dbnc = 8'd0;
    drive(1, 1, 0, 0, 0); step(); step();
    check("R2", 6'b110011);
    drive(0, 1, 0, 1, 1); step();
    check("R9", 6'b000000);
    drive(0, 1, 0, 0, 0); step();
    check("R9", 6'b000000);

    // R7: card present but rail down is not acted on
    drive(1, 0, 1, 0, 0);
    repeat (5) step();
    check("R7", 6'b000000);

    // R7: rail loss while in PCIe mode
    drive(1, 1, 0, 0, 0); step(); step();
    drive(1, 1, 0, 1, 1); step();
    drive(1, 1, 0, 0, 0); step(); step();
    check("R6", 6'b001110);
    drive(1, 0, 0, 0, 0); step();
    check("R7", 6'b000000);

    // R10: debounce restarts after a bounce
    dbnc = 8'd3;
    drive(1, 1, 1, 0, 0); step(); step(); step();
    drive(0, 1, 1, 0, 0); step();
    drive(1, 1, 1, 0, 0); step(); step(); step(); step();
    check("R10", 6'b000000);
    step();
    check("R10", 6'b110011);

    // R4: noise on non-flag bits keeps the SD path
    drive(1, 1, 0, 1, 0); resp = 12'hEFF; step();
    check("R4", 6'b100001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule